// File: doc/BRIEF.md
# DRAM Controller Boot Configuration Sequencer

This block brings up an external DRAM controller in hardware, with no boot firmware involved. A one-cycle start pulse captures a set of configuration words: PHY control, the SDRAM config word, two timing words, the refresh control word, a mobile-only config word and a slew word. It also captures two straps, one saying the memory is mobile DDR and one saying the memory accepts self-refresh-range commands. The block then drives a register bus into the controller. It issues writes and read-modify-write sequences, and it asks a power/clock controller for a sync-reset transition followed by an enable transition. It finishes by writing a pattern to the memory, reading it back and writing the read value again, which makes the controller apply the new timings.

The controller wakes up in DDR2 mode. In that mode its write to mode register 1 has the same bits as a mobile-DDR self-refresh-range command, so a memory that honours that command can hang. When both straps are set, the block runs the whole register pass a second time. The slew word goes out once for any mobile memory, between the first pass and any second pass. On the command channel a command is transferred when `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` stays low, `cmd_valid`, `cmd_write`, `cmd_addr` and `cmd_wdata` hold their values. A read returns its data on the response channel, taken when `rsp_valid` and `rsp_ready` are both high. `rsp_ready` is raised only while a read is outstanding.

Top module: `dram_boot_seq`

## Requirements
- R1: Right after reset, busy, done, err, cmd_valid, rsp_ready and pwr_req are all low.
- R2: A start pulse while idle samples every configuration input and strap. busy stays high until the run ends, done is high for exactly one cycle at the end, and changes to the inputs during the run have no effect.
- R3: The config word (register offset 0x04) is written twice with bits 23 and 15 cleared from the captured value. The first write has bit 23 (boot unlock) set. The second has bit 15 (timing unlock) set.
- R4: The mobile config word (offset 0x1C) is written only if bit 25 of the config word is set. Otherwise no access to 0x1C occurs.
- R5: One pass issues, in order: PHY (0x10), the two config writes, the optional mobile config, timing 1 (0x08), timing 2 (0x0C), the config-lock step, refresh (0x14), refresh sleep, sync-reset, enable, refresh wake, then the memory pattern steps.
- R6: The lock, sleep and wake steps each read the register and write back the read value with one change. The lock step clears bit 15 of the config register. The sleep step sets bits 31:30 of the refresh register. The wake step clears bits 31:30 of the refresh register.
- R7: Power requests hold pwr_req with a stable pwr_tgt until pwr_ack is seen. Sync-reset (pwr_tgt=0) is requested before enable (pwr_tgt=1).
- R8: Each pass ends with a write of 0xA55AA55A to MEM_BASE, then a read of MEM_BASE, then a write of the read value back to MEM_BASE.
- R9: The slew word (offset 0x20) is written exactly once when the mobile strap is set, right after the first pass. It is never written otherwise.
- R10: When both the mobile and self-refresh-range straps are set, the full pass runs a second time after the slew write. Otherwise it runs once.
- R11: If pwr_ack does not arrive within TIMEOUT_CYC cycles of a request, err rises, busy falls, done does not pulse and no further command is issued. err clears at the next start.
- R12: cmd_valid and cmd_valid with rsp_ready are never asserted together with pwr_req, and a command held without cmd_ready keeps its address, data and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| strap_mobile | input | 1 | Memory is mobile DDR |
| strap_srr | input | 1 | Memory supports self-refresh-range commands |
| phy_word | input | 32 | PHY control word |
| cfg_word | input | 32 | SDRAM config word |
| tim1_word | input | 32 | Timing word 1 |
| tim2_word | input | 32 | Timing word 2 |
| rfsh_word | input | 32 | Refresh control word |
| mcfg_word | input | 32 | Mobile-only config word |
| slew_word | input | 32 | Slew configuration word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Power handshake timed out |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Read data accepted |
| rsp_rdata | input | 32 | Read data |
| pwr_req | output | 1 | Power transition request |
| pwr_tgt | output | 1 | 0 = sync-reset, 1 = enable |
| pwr_ack | input | 1 | Power transition acknowledge |

## Verification
The assertions check some properties on every cycle. A stalled command stays frozen, a power request holds its target until acknowledged, and the bus and power requests never overlap. The block is quiet while idle, configuration captured at start stays fixed during a run, and a timeout raises err and ends the run. Only the bench scenarios can show that the command stream has the right order, data and read-modify-write values. They also show that the mobile config write depends on bit 25, that the slew word is written once, and that the second pass appears only when both straps are set.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam int BOOT_UNLOCK_BIT = 23;
  localparam int TIM_UNLOCK_BIT  = 15;
  localparam int MOBILE_EN_BIT   = 25;

  localparam word_t BOOT_MASK      = word_t'(1) << BOOT_UNLOCK_BIT;
  localparam word_t TIM_MASK       = word_t'(1) << TIM_UNLOCK_BIT;
  localparam word_t SLEEP_MASK     = 32'hC000_0000;
  localparam word_t DUMMY_PATTERN  = 32'hA55A_A55A;

  localparam logic [7:0] OFS_CFG  = 8'h04;
  localparam logic [7:0] OFS_TIM1 = 8'h08;
  localparam logic [7:0] OFS_TIM2 = 8'h0C;
  localparam logic [7:0] OFS_PHY  = 8'h10;
  localparam logic [7:0] OFS_RFSH = 8'h14;
  localparam logic [7:0] OFS_MCFG = 8'h1C;
  localparam logic [7:0] OFS_SLEW = 8'h20;

  typedef enum logic [3:0] {
    STP_PHY, STP_CFG_BOOT, STP_CFG_TIM, STP_MCFG, STP_TIM1, STP_TIM2,
    STP_CFG_LOCK, STP_RFSH, STP_RFSH_SLEEP, STP_PWR_RST, STP_PWR_EN,
    STP_RFSH_WAKE, STP_MEM_WR, STP_MEM_RB, STP_SLEW, STP_END
  } step_e;

  typedef enum logic [2:0] {OP_WR, OP_RMW, OP_PWR, OP_SKIP, OP_END} op_e;

  typedef struct packed {
    word_t phy;
    word_t cfg;
    word_t tim1;
    word_t tim2;
    word_t rfsh;
    word_t mcfg;
    word_t slew;
    logic  mobile;
    logic  srr;
  } cfg_set_t;
endpackage

// File: rtl/dbs_step_dec.sv
module dbs_step_dec
  import dbs_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] MEM_BASE = 16'h8000
) (
  input  step_e             step,
  input  logic              pass,
  input  cfg_set_t          cs,
  output op_e               op,
  output logic [ADDR_W-1:0] addr,
  output word_t             wdata,
  output word_t             and_mask,
  output word_t             or_mask,
  output logic              pwr_tgt,
  output step_e             next,
  output logic              next_pass
);
  function automatic logic [ADDR_W-1:0] reg_a(input logic [7:0] o);
    return {{(ADDR_W-8){1'b0}}, o};
  endfunction

  word_t cfg_clean;
  assign cfg_clean = cs.cfg & ~(BOOT_MASK | TIM_MASK);

  always_comb begin
    op        = OP_WR;
    addr      = '0;
    wdata     = '0;
    and_mask  = '1;
    or_mask   = '0;
    pwr_tgt   = 1'b0;
    next      = STP_END;
    next_pass = pass;
    case (step)
      STP_PHY:      begin addr = reg_a(OFS_PHY); wdata = cs.phy; next = STP_CFG_BOOT; end
      STP_CFG_BOOT: begin addr = reg_a(OFS_CFG); wdata = cfg_clean | BOOT_MASK; next = STP_CFG_TIM; end
      STP_CFG_TIM:  begin addr = reg_a(OFS_CFG); wdata = cfg_clean | TIM_MASK;  next = STP_MCFG; end
      STP_MCFG: begin
        op    = cfg_clean[MOBILE_EN_BIT] ? OP_WR : OP_SKIP;
        addr  = reg_a(OFS_MCFG);
        wdata = cs.mcfg;
        next  = STP_TIM1;
      end
      STP_TIM1:     begin addr = reg_a(OFS_TIM1); wdata = cs.tim1; next = STP_TIM2; end
      STP_TIM2:     begin addr = reg_a(OFS_TIM2); wdata = cs.tim2; next = STP_CFG_LOCK; end
      STP_CFG_LOCK: begin op = OP_RMW; addr = reg_a(OFS_CFG); and_mask = ~TIM_MASK; next = STP_RFSH; end
      STP_RFSH:     begin addr = reg_a(OFS_RFSH); wdata = cs.rfsh; next = STP_RFSH_SLEEP; end
      STP_RFSH_SLEEP: begin op = OP_RMW; addr = reg_a(OFS_RFSH); or_mask = SLEEP_MASK; next = STP_PWR_RST; end
      STP_PWR_RST:  begin op = OP_PWR; pwr_tgt = 1'b0; next = STP_PWR_EN; end
      STP_PWR_EN:   begin op = OP_PWR; pwr_tgt = 1'b1; next = STP_RFSH_WAKE; end
      STP_RFSH_WAKE: begin op = OP_RMW; addr = reg_a(OFS_RFSH); and_mask = ~SLEEP_MASK; next = STP_MEM_WR; end
      STP_MEM_WR:   begin addr = MEM_BASE; wdata = DUMMY_PATTERN; next = STP_MEM_RB; end
      STP_MEM_RB: begin
        op   = OP_RMW;
        addr = MEM_BASE;
        next = (!pass && cs.mobile) ? STP_SLEW : STP_END;
      end
      STP_SLEW: begin
        addr      = reg_a(OFS_SLEW);
        wdata     = cs.slew;
        next      = cs.srr ? STP_PHY : STP_END;
        next_pass = cs.srr ? 1'b1 : pass;
      end
      default: op = OP_END;
    endcase
  end
endmodule

// File: rtl/dbs_pwr_hs.sv
module dbs_pwr_hs #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic tgt_in,
  input  logic pwr_ack,
  output logic pwr_req,
  output logic pwr_tgt,
  output logic ok,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign ok      = pwr_req && pwr_ack;
  assign expired = pwr_req && !pwr_ack && (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_req <= 1'b0;
      pwr_tgt <= 1'b0;
      cnt     <= '0;
    end else if (go) begin
      pwr_req <= 1'b1;
      pwr_tgt <= tgt_in;
      cnt     <= '0;
    end else if (pwr_req) begin
      if (pwr_ack || cnt == LIMIT) pwr_req <= 1'b0;
      else                         cnt     <= cnt + 1'b1;
    end
  end

  // R7: request held with stable target until acknowledged or timed out
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req && !pwr_ack && !expired |=> pwr_req && $stable(pwr_tgt));
endmodule

// File: rtl/dram_boot_seq.sv
module dram_boot_seq
  import dbs_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] MEM_BASE    = 16'h8000,
  parameter int                TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              strap_mobile,
  input  logic              strap_srr,
  input  logic [31:0]       phy_word,
  input  logic [31:0]       cfg_word,
  input  logic [31:0]       tim1_word,
  input  logic [31:0]       tim2_word,
  input  logic [31:0]       rfsh_word,
  input  logic [31:0]       mcfg_word,
  input  logic [31:0]       slew_word,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [31:0]       cmd_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_rdata,
  output logic              pwr_req,
  output logic              pwr_tgt,
  input  logic              pwr_ack
);
  typedef enum logic [2:0] {ST_IDLE, ST_DECODE, ST_WR, ST_RD, ST_RSP, ST_PWR} state_e;

  state_e   state;
  step_e    step;
  logic     pass;
  cfg_set_t cs;
  word_t    wr_data;

  op_e               d_op;
  logic [ADDR_W-1:0] d_addr;
  word_t             d_wdata, d_and, d_or;
  logic              d_tgt, d_next_pass;
  step_e             d_next;
  logic              hs_go, hs_ok, hs_expired;

  dbs_step_dec #(.ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE)) u_dec (
    .step(step), .pass(pass), .cs(cs), .op(d_op), .addr(d_addr),
    .wdata(d_wdata), .and_mask(d_and), .or_mask(d_or), .pwr_tgt(d_tgt),
    .next(d_next), .next_pass(d_next_pass)
  );

  assign hs_go = (state == ST_DECODE) && (d_op == OP_PWR);

  dbs_pwr_hs #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .go(hs_go), .tgt_in(d_tgt), .pwr_ack(pwr_ack),
    .pwr_req(pwr_req), .pwr_tgt(pwr_tgt), .ok(hs_ok), .expired(hs_expired)
  );

  assign busy      = (state != ST_IDLE);
  assign cmd_valid = (state == ST_WR) || (state == ST_RD);
  assign cmd_write = (state == ST_WR);
  assign cmd_addr  = d_addr;
  assign cmd_wdata = wr_data;
  assign rsp_ready = (state == ST_RSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      step    <= STP_PHY;
      pass    <= 1'b0;
      cs      <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cs    <= '{phy: phy_word, cfg: cfg_word, tim1: tim1_word, tim2: tim2_word,
                     rfsh: rfsh_word, mcfg: mcfg_word, slew: slew_word,
                     mobile: strap_mobile, srr: strap_srr};
          step  <= STP_PHY;
          pass  <= 1'b0;
          err   <= 1'b0;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          case (d_op)
            OP_WR:   begin wr_data <= d_wdata; state <= ST_WR; end
            OP_RMW:  state <= ST_RD;
            OP_PWR:  state <= ST_PWR;
            OP_SKIP: begin step <= d_next; pass <= d_next_pass; end
            default: begin done <= 1'b1; state <= ST_IDLE; end
          endcase
        end
        ST_WR: if (cmd_ready) begin
          step  <= d_next;
          pass  <= d_next_pass;
          state <= ST_DECODE;
        end
        ST_RD: if (cmd_ready) state <= ST_RSP;
        ST_RSP: if (rsp_valid) begin
          wr_data <= (rsp_rdata & d_and) | d_or;
          state   <= ST_WR;
        end
        ST_PWR: begin
          if (hs_ok) begin
            step  <= d_next;
            state <= ST_DECODE;
          end else if (hs_expired) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: stalled command keeps its content
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_write));
  // R12: bus and power activity never overlap
  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !((cmd_valid || rsp_ready) && pwr_req));
  // R2: nothing is driven while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !rsp_ready && !pwr_req);
  // R2: done is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: captured configuration stays fixed during a run
  p_cfg_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && state != ST_DECODE |=> $stable(cs) || !busy);
  // R11: a timeout flags the error and ends the run
  p_timeout_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_expired |=> err && !busy && !done);
endmodule

// File: tb/sim_dram_boot_seq.sv
module sim_dram_boot_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MEMB = 16'h8000;
  localparam logic [31:0] BM = 32'h0080_0000, TM = 32'h0000_8000, SM = 32'hC000_0000;

  logic clk = 0, rst_n = 0, start = 0, strap_mobile = 0, strap_srr = 0;
  logic [31:0] phy_word = 0, cfg_word = 0, tim1_word = 0, tim2_word = 0;
  logic [31:0] rfsh_word = 0, mcfg_word = 0, slew_word = 0;
  logic busy, done, err, cmd_valid, cmd_write, rsp_ready, pwr_req, pwr_tgt;
  logic cmd_ready = 0, rsp_valid = 0, pwr_ack = 0;
  logic [15:0] cmd_addr;
  logic [31:0] cmd_wdata, rsp_rdata = 0;

  int tests = 0, fails = 0, cyc = 0;
  bit ack_en = 1;

  dram_boot_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // bus and power models; log: kind 0=read 1=write 2=power
  logic [1:0]  lg_k [0:127];
  logic [15:0] lg_a [0:127];
  logic [31:0] lg_d [0:127];
  int lg_n = 0;
  logic [1:0]  ex_k [0:127];
  logic [15:0] ex_a [0:127];
  logic [31:0] ex_d [0:127];
  int ex_n = 0;
  logic [31:0] regs [0:15];
  logic [31:0] memw = 0;
  logic [1:0] rdy_cnt = 0;
  int ack_dly = 0;

  always @(posedge clk) begin
    rdy_cnt   <= rdy_cnt + 1'b1;
    cmd_ready <= (rdy_cnt != 2'd2);
    if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    if (cmd_valid && cmd_ready) begin
      if (cmd_write) begin
        if (cmd_addr == MEMB) memw <= cmd_wdata; else regs[cmd_addr[5:2]] <= cmd_wdata;
        lg_k[lg_n] <= 2'd1; lg_d[lg_n] <= cmd_wdata;
      end else begin
        rsp_valid <= 1'b1;
        rsp_rdata <= (cmd_addr == MEMB) ? memw : regs[cmd_addr[5:2]];
        lg_k[lg_n] <= 2'd0; lg_d[lg_n] <= (cmd_addr == MEMB) ? memw : regs[cmd_addr[5:2]];
      end
      lg_a[lg_n] <= cmd_addr;
      lg_n <= lg_n + 1;
    end
    pwr_ack <= 1'b0;
    if (!pwr_req) ack_dly <= 0;
    else if (ack_en && !pwr_ack) begin
      if (ack_dly == 3) begin
        pwr_ack <= 1'b1;
        lg_k[lg_n] <= 2'd2; lg_a[lg_n] <= 16'h0; lg_d[lg_n] <= {31'd0, pwr_tgt};
        lg_n <= lg_n + 1;
      end else ack_dly <= ack_dly + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] a, input logic [31:0] d);
    ex_k[ex_n] = k; ex_a[ex_n] = (a == 8'hFF) ? MEMB : {8'h00, a}; ex_d[ex_n] = d; ex_n++;
  endtask

  task automatic exp_pass(input logic [31:0] phy, cfg, t1, t2, rf, mc, input bit upto_sleep);
    logic [31:0] cl;
    cl = cfg & ~(BM | TM);
    push(1, 8'h10, phy); push(1, 8'h04, cl | BM); push(1, 8'h04, cl | TM);
    if (cl[25]) push(1, 8'h1C, mc);
    push(1, 8'h08, t1); push(1, 8'h0C, t2);
    push(0, 8'h04, cl | TM); push(1, 8'h04, cl);
    push(1, 8'h14, rf); push(0, 8'h14, rf); push(1, 8'h14, rf | SM);
    if (upto_sleep) return;
    push(2, 8'h00, 0); push(2, 8'h00, 1);
    push(0, 8'h14, rf | SM); push(1, 8'h14, rf & ~SM);
    push(1, 8'hFF, 32'hA55A_A55A); push(0, 8'hFF, 32'hA55A_A55A); push(1, 8'hFF, 32'hA55A_A55A);
  endtask

  task automatic kick(input logic [31:0] phy, cfg, t1, t2, rf, mc, sl, input bit mob, srr);
    @(negedge clk);
    lg_n = 0; ex_n = 0;
    phy_word = phy; cfg_word = cfg; tim1_word = t1; tim2_word = t2;
    rfsh_word = rf; mcfg_word = mc; slew_word = sl; strap_mobile = mob; strap_srr = srr;
    start = 1;
    @(negedge clk);
    start = 0;
    // R2: scramble inputs during the run; they must be ignored
    phy_word = ~phy; cfg_word = ~cfg; tim1_word = 0; tim2_word = 0;
    rfsh_word = 0; mcfg_word = 0; slew_word = 0; strap_mobile = ~mob; strap_srr = ~srr;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
  endtask

  task automatic run_case(input string name, input logic [31:0] phy, cfg, t1, t2, rf, mc, sl,
                          input bit mob, srr);
    int n, busy_gap, slew_n, phy_n, mc_n;
    kick(phy, cfg, t1, t2, rf, mc, sl, mob, srr);
    exp_pass(phy, cfg, t1, t2, rf, mc, 0);
    if (mob) push(1, 8'h20, sl);
    if (mob && srr) exp_pass(phy, cfg, t1, t2, rf, mc, 0);
    n = 0; busy_gap = 0;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
      if (!busy && !done) busy_gap++;
    end
    chk(done == 1'b1, "R2", {name, " done seen"}, done, 1);
    chk(busy_gap == 0, "R2", {name, " busy held"}, busy_gap, 0);
    chk(err == 1'b0, "R11", {name, " no err"}, err, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R2", {name, " done single pulse"}, {done, busy}, 0);
    chk(lg_n == ex_n, "R5", {name, " access count"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      chk(lg_k[i] == ex_k[i] && lg_a[i] == ex_a[i] && lg_d[i] == ex_d[i],
          (ex_k[i] == 2) ? "R7" : (ex_k[i] == 0) ? "R6" : "R5",
          $sformatf("%s entry %0d kind%0d addr%h", name, i, ex_k[i], ex_a[i]), lg_d[i], ex_d[i]);
    end
    slew_n = 0; phy_n = 0; mc_n = 0;
    for (int i = 0; i < lg_n; i++) begin
      if (lg_a[i] == 16'h20) slew_n++;
      if (lg_a[i] == 16'h10) phy_n++;
      if (lg_a[i] == 16'h1C) mc_n++;
    end
    chk(slew_n == (mob ? 1 : 0), "R9", {name, " slew writes"}, slew_n, mob ? 1 : 0);
    chk(phy_n == ((mob && srr) ? 2 : 1), "R10", {name, " pass count"}, phy_n, (mob && srr) ? 2 : 1);
    chk(mc_n == (((cfg & ~(BM | TM)) >> 25) & 1) * phy_n, "R4", {name, " mobile cfg writes"}, mc_n, 0);
    chk(lg_d[1] == ((cfg & ~(BM | TM)) | BM), "R3", {name, " boot-unlock write"}, lg_d[1], (cfg & ~(BM | TM)) | BM);
    chk(lg_a[ex_n-1] == (mob ? 16'h20 : MEMB) || (mob && srr), "R8", {name, " final access"}, lg_a[ex_n-1], 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !err && !cmd_valid && !rsp_ready && !pwr_req, "R1", "reset state",
        {busy, done, err, cmd_valid, rsp_ready, pwr_req}, 0);
  endtask

  task automatic t_timeout;
    int n;
    ack_en = 0;
    kick(32'h1111_0001, 32'h0280_8055, 32'h2, 32'h3, 32'h0000_0444, 32'h5, 32'h6, 1, 1);
    exp_pass(32'h1111_0001, 32'h0280_8055, 32'h2, 32'h3, 32'h0000_0444, 32'h5, 1);
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; chk(!done, "R11", "no done on timeout", done, 0); end
    chk(err == 1'b1, "R11", "err raised", err, 1);
    chk(busy == 1'b0, "R11", "busy dropped", busy, 0);
    chk(n >= 1024, "R11", "timeout not early", n, 1024);
    repeat (5) @(negedge clk);
    chk(lg_n == ex_n, "R11", "no access after timeout", lg_n, ex_n);
    chk(err == 1'b1, "R11", "err held", err, 1);
    ack_en = 1;
    kick(32'h1, 32'h0, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 0, 0);
    chk(err == 1'b0, "R11", "err cleared by start", err, 0);
    while (busy) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_case("ddr2", 32'hABCD_0001, 32'h0080_8123, 32'h1357_9BDF, 32'h2468_ACE0,
             32'hC000_0777, 32'h5555_AAAA, 32'h0000_00FF, 0, 0);
    run_case("mobile", 32'h0000_0101, 32'h0200_0042, 32'h0F0F_0F0F, 32'hF0F0_F0F0,
             32'h0000_1234, 32'h7777_0000, 32'h0000_0012, 1, 0);
    run_case("mobile_srr", 32'h0000_0202, 32'h0280_8042, 32'h1111_1111, 32'h2222_2222,
             32'h4000_0999, 32'h3333_0000, 32'h0000_0034, 1, 1);
    run_case("strap_no_bit", 32'h0000_0303, 32'h0000_0001, 32'h1, 32'h2,
             32'h0000_0010, 32'h3, 32'h0000_0056, 1, 1);
    t_timeout();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule